// File: doc/BRIEF.md
# Flash Command Interface Controller

This block fronts a word-organized flash array that is modelled in on-chip RAM. A host drives a parallel bus of active-low chip enable, write enable and output enable lines with a word address and 16-bit data. The bus is sampled on the system clock. Write cycles on the bus are not stored directly: each one is decoded as a command. The commands pick what a read returns (array contents, identifier codes or the status register), clear errors, or start an operation in the write state machine.

The write state machine runs two operations. A word write ANDs new data into the stored word, after a programmable busy time. A block erase fills one block with all-ones, one word per clock. Either operation can be suspended and resumed. While an erase is suspended the host may read other blocks and write words in them. While a write is suspended the host may read other locations.

Erase regions follow a non-uniform top-boot map. The lower fifteen sixteenths of the address space form fifteen equal large blocks. The top sixteenth is split into eight small blocks: six parameter blocks and then two boot blocks. The default `ADDR_W` of 10 scales the map down. The 19-bit layout uses block sizes of 32K and 4K words; here each is divided by 512 (64 and 8 words). The proportions stay the same.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and on the clock after `pdown` falls, the controller is in array-read mode with status 0x80 (no suspend, no error). While `pdown` is high, `dout_en` and `dout` are 0. Array words start at 0xFFFF.
- R2: Command byte 0x90 selects identifier reads: an even address returns `ID_MFR` and an odd address returns `ID_DEV`. Byte 0x70 selects status reads, which return the status in bits 7:0 with bits 15:8 zero. Byte 0xFF selects array reads.
- R3: A write cycle with byte 0x40 followed by a write cycle carrying address A and data D leaves the word at A equal to old AND D. When it finishes, the status reads 0x80.
- R4: A write cycle with 0x20 followed by one with 0xD0 at any address inside a block sets every word of that block to 0xFFFF. No word outside the block changes. Large blocks are 2^(ADDR_W-4) words and start at multiples of that size. In the top sixteenth, blocks are 2^(ADDR_W-7) words.
- R5: If the write cycle after 0x20 carries any byte other than 0xD0, status bit 5 (erase error) and bit 4 (write error) are set and no array word changes.
- R6: Status bits 5 and 4 stay set across other commands until a 0x50 command clears them.
- R7: While the write state machine is busy, every read returns the status with bit 7 (ready) at 0, whatever read mode was selected.
- R8: When an operation completes, reads keep returning the status until a 0xFF command is written.
- R9: Byte 0xB0 during an erase stops it. The status then reads ready with bit 6 set. Other blocks can then be read and written. A later 0xD0 resumes the erase from the saved position and completes the whole block.
- R10: Byte 0xB0 during a word write pauses it. The status then reads ready with bit 2 set. Other locations can be read. A later 0xD0 resumes the write and completes it.
- R11: Address and data are captured in the clock cycle a write cycle begins. Later changes on the bus do not affect the command.
- R12: During a suspended erase, a word write aimed at the suspended block sets the write error bit and changes no word.
- R13: `dout_en` is high, and `dout` carries data, only while chip enable and output enable are low and write enable is high. Otherwise `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pdown | input | 1 | Deep power-down; resets the controller, not the array |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data and command byte (bits 7:0) |
| dout | output | DATA_W | Registered read data |
| dout_en | output | 1 | Read data valid |

## Verification
The assertions assume the host follows the bus rules. Each write pulse holds chip enable and write enable low for at least one sampled clock. Pulses are separated by at least one clock with write enable high. Output enable and write enable are never low at the same time. The bench tasks keep to these rules: every write pulse lasts two clocks and is followed by two idle clocks, and reads hold the address for four clocks before sampling. After each write pulse the bench scrambles the address and data lines, so any late capture would corrupt the result.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_ID, RM_STAT} rmode_t;
  typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_WRITE} pend_t;
  typedef enum logic [2:0] {WS_IDLE, WS_PROG, WS_FETCH, WS_STORE, WS_ERASE} wstate_t;

  localparam logic [7:0] OP_READ    = 8'hFF;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_WRITE   = 8'h40;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;

  localparam int SB_READY = 7;
  localparam int SB_ESUSP = 6;
  localparam int SB_EERR  = 5;
  localparam int SB_WERR  = 4;
  localparam int SB_WSUSP = 2;
endpackage

// File: rtl/fcc_block_map.sv
module fcc_block_map #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] mask
);
  localparam int BIG_W   = ADDR_W - 4;
  localparam int SMALL_W = ADDR_W - 7;
  localparam logic [ADDR_W-1:0] BIG_MASK   = {{4{1'b0}}, {BIG_W{1'b1}}};
  localparam logic [ADDR_W-1:0] SMALL_MASK = {{7{1'b0}}, {SMALL_W{1'b1}}};

  always_comb begin
    if (addr[ADDR_W-1 -: 4] == 4'hF) mask = SMALL_MASK;
    else                             mask = BIG_MASK;
    base = addr & ~mask;
  end
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fcc_wsm.sv
module fcc_wsm
  import fcc_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_write,
  input  logic              start_erase,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] tgt_mask,
  input  logic [DATA_W-1:0] tgt_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              esusp,
  output logic              wsusp,
  output logic [ADDR_W-1:0] ers_base,
  output logic [ADDR_W-1:0] ers_mask,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr
);
  localparam int PCW = $clog2(PROG_CYC + 1);

  wstate_t           st;
  logic [ADDR_W-1:0] ecnt;
  logic [ADDR_W-1:0] w_addr;
  logic [DATA_W-1:0] w_data;
  logic [PCW-1:0]    pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= WS_IDLE; esusp <= 1'b0; wsusp <= 1'b0;
      ecnt <= '0; ers_base <= '0; ers_mask <= '0;
      w_addr <= '0; w_data <= '0; pcnt <= '0;
    end else begin
      case (st)
        WS_IDLE: begin
          if (start_write) begin
            w_addr <= tgt_addr; w_data <= tgt_data;
            pcnt <= PCW'(PROG_CYC - 1); st <= WS_PROG;
          end else if (start_erase) begin
            ers_base <= tgt_addr & ~tgt_mask; ers_mask <= tgt_mask;
            ecnt <= '0; st <= WS_ERASE;
          end else if (resume_req) begin
            if (wsusp) begin
              wsusp <= 1'b0; st <= WS_PROG;
            end else if (esusp) begin
              esusp <= 1'b0; st <= WS_ERASE;
            end
          end
        end
        WS_PROG: begin
          if (susp_req) begin
            wsusp <= 1'b1; st <= WS_IDLE;
          end else if (pcnt == '0) st <= WS_FETCH;
          else pcnt <= pcnt - 1'b1;
        end
        WS_FETCH: st <= WS_STORE;
        WS_STORE: st <= WS_IDLE;
        WS_ERASE: begin
          if (susp_req) begin
            esusp <= 1'b1; st <= WS_IDLE;
          end else if (ecnt == ers_mask) st <= WS_IDLE;
          else ecnt <= ecnt + 1'b1;
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

  assign busy      = (st != WS_IDLE);
  assign mem_raddr = w_addr;
  assign mem_we    = (st == WS_STORE) || (st == WS_ERASE && !susp_req);
  assign mem_waddr = (st == WS_STORE) ? w_addr : (ers_base | ecnt);
  assign mem_wdata = (st == WS_STORE) ? (mem_rdata & w_data) : '1;

  AST_ERASE_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (mem_we && st == WS_ERASE) |-> ((mem_waddr & ~ers_mask) == ers_base)); // R4
  AST_ECNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    ((ecnt & ~ers_mask) == '0)); // R4
  AST_ESUSP_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(esusp) |-> (st == WS_IDLE && !mem_we)); // R9
  AST_WSUSP_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(wsusp) |-> (st == WS_IDLE)); // R10
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter int              DATA_W   = 16,
  parameter int              PROG_CYC = 16,
  parameter logic [DATA_W-1:0] ID_MFR = 16'h005A,
  parameter logic [DATA_W-1:0] ID_DEV = 16'h00C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdown,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              s_ce_n, s_we_n, s_oe_n, wr_prev;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din;
  logic              ctl_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ce_n <= 1'b1; s_we_n <= 1'b1; s_oe_n <= 1'b1; wr_prev <= 1'b0;
      s_addr <= '0; s_din <= '0;
    end else begin
      s_ce_n <= ce_n; s_we_n <= we_n; s_oe_n <= oe_n;
      s_addr <= addr; s_din <= din;
      wr_prev <= ~s_ce_n & ~s_we_n;
    end
  end

  assign ctl_rst = rst | pdown;
  wire       cmd_ev = ~s_ce_n & ~s_we_n & ~wr_prev;
  wire [7:0] cmd    = s_din[7:0];

  rmode_t            mode;
  pend_t             pend;
  logic              eerr, werr;
  logic              busy, esusp, wsusp;
  logic [ADDR_W-1:0] map_base, map_mask, ers_base, ers_mask;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, wsm_raddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  fcc_block_map #(.ADDR_W(ADDR_W)) u_map (
    .addr(s_addr), .base(map_base), .mask(map_mask));

  wire hits_susp   = esusp && ((s_addr & ~ers_mask) == ers_base);
  wire start_write = cmd_ev && pend == PD_WRITE && !hits_susp;
  wire start_erase = cmd_ev && pend == PD_ERASE && cmd == OP_CONFIRM;
  wire susp_req    = cmd_ev && pend == PD_NONE && cmd == OP_SUSPEND && busy;
  wire resume_req  = cmd_ev && pend == PD_NONE && cmd == OP_CONFIRM && !busy;
  wire clear_req   = cmd_ev && pend == PD_NONE && cmd == OP_CLEAR;

  fcc_wsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC)) u_wsm (
    .clk(clk), .rst(ctl_rst),
    .start_write(start_write), .start_erase(start_erase),
    .susp_req(susp_req), .resume_req(resume_req),
    .tgt_addr(s_addr), .tgt_mask(map_mask), .tgt_data(s_din),
    .mem_rdata(mem_rdata),
    .busy(busy), .esusp(esusp), .wsusp(wsusp),
    .ers_base(ers_base), .ers_mask(ers_mask),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(wsm_raddr));

  assign mem_raddr = busy ? wsm_raddr : s_addr;

  fcc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (ctl_rst) begin
      mode <= RM_ARRAY; pend <= PD_NONE; eerr <= 1'b0; werr <= 1'b0;
    end else if (cmd_ev) begin
      case (pend)
        PD_WRITE: begin
          pend <= PD_NONE; mode <= RM_STAT;
          if (hits_susp) werr <= 1'b1;
        end
        PD_ERASE: begin
          pend <= PD_NONE; mode <= RM_STAT;
          if (cmd != OP_CONFIRM) begin eerr <= 1'b1; werr <= 1'b1; end
        end
        default: begin
          case (cmd)
            OP_READ:    mode <= RM_ARRAY;
            OP_IDENT:   mode <= RM_ID;
            OP_STATUS:  mode <= RM_STAT;
            OP_CLEAR:   begin eerr <= 1'b0; werr <= 1'b0; end
            OP_ERASE:   if (!busy && !esusp && !wsusp) pend <= PD_ERASE;
            OP_WRITE:   if (!busy && !wsusp) pend <= PD_WRITE;
            OP_SUSPEND: mode <= RM_STAT;
            OP_CONFIRM: mode <= RM_STAT;
            default: ;
          endcase
        end
      endcase
    end
  end

  wire [7:0] sr = {~busy, esusp, eerr, werr, 1'b0, wsusp, 2'b00};

  logic   rd_a, lsb_a;
  rmode_t sel_a;
  logic [7:0] sr_a;

  always_ff @(posedge clk) begin
    if (ctl_rst) begin
      rd_a <= 1'b0; lsb_a <= 1'b0; sel_a <= RM_ARRAY; sr_a <= '0;
      dout <= '0; dout_en <= 1'b0;
    end else begin
      rd_a  <= ~s_ce_n & ~s_oe_n & s_we_n;
      lsb_a <= s_addr[0];
      sel_a <= busy ? RM_STAT : mode;
      sr_a  <= sr;
      dout_en <= rd_a;
      if (!rd_a)                dout <= '0;
      else if (sel_a == RM_STAT) dout <= {{(DATA_W-8){1'b0}}, sr_a};
      else if (sel_a == RM_ID)   dout <= lsb_a ? ID_DEV : ID_MFR;
      else                       dout <= mem_rdata;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (ctl_rst)
    (eerr && !clear_req) |=> eerr); // R6
  AST_WERR_STICKY: assert property (@(posedge clk) disable iff (ctl_rst)
    (werr && !clear_req) |=> werr); // R6
  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (ctl_rst)
    (busy && ~s_ce_n && ~s_oe_n && s_we_n) |=> ##1 (dout[SB_READY] == 1'b0 && dout[DATA_W-1:8] == '0)); // R7
  AST_PDOWN_ARRAY: assert property (@(posedge clk) disable iff (rst)
    $fell(pdown) |-> (mode == RM_ARRAY && pend == PD_NONE && !busy)); // R1
  AST_NO_OUT_IDLE: assert property (@(posedge clk) disable iff (ctl_rst)
    !dout_en |=> (dout_en || dout == '0)); // R13
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [15:0] MFR = 16'h005A;
  localparam logic [15:0] DEV = 16'h00C3;

  logic clk = 1'b0;
  logic rst = 1'b1, pdown = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] mdl [DEPTH];

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(16), .ID_MFR(MFR), .ID_DEV(DEV)) dut (
    .clk(clk), .rst(rst), .pdown(pdown), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  function automatic logic [AW-1:0] bmask(input logic [AW-1:0] a);
    return (a[AW-1 -: 4] == 4'hF) ? AW'(7) : AW'(63);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; din = d;
    repeat (2) @(negedge clk);
    we_n = 1; ce_n = 1; addr = AW'($urandom); din = 16'($urandom);  // R11 scramble
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] v);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    repeat (4) @(negedge clk);
    v = dout;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready(output logic [15:0] v);
    v = '0;
    for (int i = 0; i < 3000; i++) begin
      bus_read('0, v);
      if (v[7]) break;
    end
  endtask

  task automatic expect_read(input string tag, input logic [AW-1:0] a, input logic [15:0] exp);
    logic [15:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic word_write(input logic [AW-1:0] a, input logic [15:0] d, input bit check_busy);
    logic [15:0] v;
    bus_write(a, 16'h0040);
    bus_write(a, d);
    if (check_busy) begin
      bus_read(a, v);
      check("R7 busy status", {v[15:8], v[7]}, 9'h000);
    end
    wait_ready(v);
    check("R3 write done status", v, 16'h0080);
    mdl[a] = mdl[a] & d;
  endtask

  task automatic erase_block(input logic [AW-1:0] a);
    logic [15:0] v;
    logic [AW-1:0] m;
    m = bmask(a);
    bus_write(a, 16'h0020);
    bus_write(a, 16'h00D0);
    wait_ready(v);
    check("R4 erase done status", v, 16'h0080);
    for (int i = 0; i < DEPTH; i++)
      if ((AW'(i) & ~m) == (a & ~m)) mdl[i] = 16'hFFFF;
  endtask

  task automatic verify_block(input string tag, input logic [AW-1:0] a);
    logic [AW-1:0] m, b;
    m = bmask(a);
    b = a & ~m;
    bus_write('0, 16'h00FF);
    for (int i = 0; i <= int'(m); i++) expect_read(tag, b | AW'(i), mdl[b | AW'(i)]);
    if (b != '0) expect_read({tag, " lower neighbour"}, b - 1'b1, mdl[b - 1'b1]);
    if ((b | m) != '1) expect_read({tag, " upper neighbour"}, (b | m) + 1'b1, mdl[(b | m) + 1'b1]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act %h exp %h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, d;
    logic [AW-1:0] a, t;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R1 reset state
    expect_read("R1 array after reset", 10'h005, 16'hFFFF);
    expect_read("R1 array after reset", 10'h3FF, 16'hFFFF);
    bus_write('0, 16'h0070);
    expect_read("R1 reset status", '0, 16'h0080);
    // R2 identifier and read modes
    bus_write('0, 16'h0090);
    expect_read("R2 ident even", 10'h000, MFR);
    expect_read("R2 ident odd", 10'h001, DEV);
    bus_write('0, 16'h00FF);
    expect_read("R2 back to array", 10'h001, 16'hFFFF);
    // R13 no output without output enable
    @(negedge clk); ce_n = 0; addr = 10'h001; repeat (4) @(negedge clk);
    check("R13 no drive oe high", {15'h0, dout_en}, 16'h0);
    check("R13 dout zero", dout, 16'h0);
    ce_n = 1; @(negedge clk);

    // R3 R7 R8 R11 random word writes
    for (int k = 0; k < 24; k++) begin
      a = AW'($urandom);
      d = 16'($urandom);
      word_write(a, d, k < 6);
      expect_read("R8 status persists", a, 16'h0080);
      bus_write('0, 16'h00FF);
      expect_read("R3 R11 word value", a, mdl[a]);
    end

    // R4 directed erases: big, parameter, boot
    word_write(10'h0C5, 16'h0000, 0);
    word_write(10'h0FF, 16'h1234, 0);
    word_write(10'h100, 16'h00F0, 0);
    erase_block(10'h0C5);
    verify_block("R4 big block", 10'h0C5);
    word_write(10'h3D3, 16'h0000, 0);
    word_write(10'h3CF, 16'h0F0F, 0);
    erase_block(10'h3D6);
    verify_block("R4 param block", 10'h3D3);
    word_write(10'h3F9, 16'h0000, 0);
    word_write(10'h3F7, 16'h00FF, 0);
    erase_block(10'h3FE);
    verify_block("R4 boot block", 10'h3F9);
    for (int k = 0; k < 3; k++) begin
      a = AW'($urandom);
      word_write(a, 16'($urandom), 0);
      erase_block(a ^ AW'($urandom % 4));
      verify_block("R4 random block", a);
    end

    // R5 bad confirm, R6 sticky
    a = 10'h0FF;
    bus_write(a, 16'h0020);
    bus_write(a, 16'h0033);
    expect_read("R5 error bits", a, 16'h00B0);
    bus_write('0, 16'h00FF);
    expect_read("R5 array unchanged", a, mdl[a]);
    bus_write('0, 16'h0090);
    bus_write('0, 16'h0070);
    expect_read("R6 errors persist", '0, 16'h00B0);
    bus_write('0, 16'h0050);
    expect_read("R6 cleared", '0, 16'h0080);

    // R9 erase suspend, R12 write into suspended block
    word_write(10'h17C, 16'h0000, 0);
    bus_write(10'h140, 16'h0020);
    bus_write(10'h140, 16'h00D0);
    bus_write('0, 16'h00B0);
    expect_read("R9 suspended status", '0, 16'h00C0);
    bus_write('0, 16'h00FF);
    expect_read("R9 read other block", 10'h0FF, mdl[10'h0FF]);
    t = 10'h1C9;
    bus_write(t, 16'h0040);
    bus_write(t, 16'h5A5A);
    wait_ready(v);
    check("R9 write during suspend", v, 16'h00C0);
    mdl[t] = mdl[t] & 16'h5A5A;
    bus_write('0, 16'h00FF);
    expect_read("R9 other block written", t, mdl[t]);
    bus_write(10'h150, 16'h0040);
    bus_write(10'h150, 16'h0000);
    expect_read("R12 write error", '0, 16'h00D0);
    bus_write('0, 16'h0050);
    expect_read("R12 cleared", '0, 16'h00C0);
    bus_write('0, 16'h00D0);
    wait_ready(v);
    check("R9 resumed done", v, 16'h0080);
    for (int i = 10'h140; i < 10'h180; i++) mdl[i] = 16'hFFFF;
    verify_block("R9 block complete", 10'h140);

    // R10 write suspend
    a = 10'h222; d = 16'h0FF0;
    word_write(a, 16'hF0F7, 0);
    bus_write(a, 16'h0040);
    bus_write(a, d);
    bus_write('0, 16'h00B0);
    expect_read("R10 suspended status", '0, 16'h0084);
    bus_write('0, 16'h00FF);
    expect_read("R10 read other", 10'h1C9, mdl[10'h1C9]);
    bus_write('0, 16'h00D0);
    wait_ready(v);
    check("R10 resumed done", v, 16'h0080);
    mdl[a] = mdl[a] & d;
    bus_write('0, 16'h00FF);
    expect_read("R10 word value", a, mdl[a]);

    // R1 deep power-down
    bus_write('0, 16'h0070);
    @(negedge clk); pdown = 1; ce_n = 0; oe_n = 0; addr = a;
    repeat (4) @(negedge clk);
    check("R1 no output in pdown", {dout_en, dout[14:0]}, 16'h0);
    ce_n = 1; oe_n = 1; pdown = 0;
    repeat (2) @(negedge clk);
    expect_read("R1 array after pdown", a, mdl[a]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule